// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that answers like a small byte-addressable serial EEPROM. Its storage is an on-chip register array. A fast system clock samples the bus. After a two-stage synchronizer, the block detects START, repeated START and STOP conditions and the rising and falling edges of SCL. It drives SDA only through an open-drain pull-down enable. It uses that enable to acknowledge bytes it receives and to send read data.

The block supports the following operations:
- **Byte write and page write.** The controller sends a write header, one or two word-address bytes and then data bytes. The data bytes are collected in a one-page buffer. The array is updated only when the STOP arrives. After that a busy window runs, and during it the target refuses its own address.
- **Random read.** The controller sends a write header and a word address with no data, then a repeated START and a read header.
- **Current-address read.** A read header with no word address returns the byte at a persistent pointer.
- **Sequential read.** The target keeps sending bytes for as long as the controller acknowledges.

A write-protect input stops data bytes from being stored.

The controller is built as one finite-state machine.

States:
- `ST_IDLE`: waits for a START.
- `ST_HEADER`: shifts in the device header.
- `ST_ADDR_HI`: shifts in the high word-address byte.
- `ST_ADDR_LO`: shifts in the low word-address byte.
- `ST_WRITE`: shifts in data bytes.
- `ST_ACK_OUT`: the target drives the acknowledge bit.
- `ST_READ`: the target shifts a byte out.
- `ST_ACK_IN`: samples the controller's acknowledge.

Transitions:
- A START goes to `ST_HEADER` from any state.
- A STOP goes to `ST_IDLE` from any state.
- `ST_HEADER` goes to `ST_ACK_OUT` on a matching header while not busy, and to `ST_IDLE` otherwise.
- The three receive states (`ST_ADDR_HI`, `ST_ADDR_LO`, `ST_WRITE`) go to `ST_ACK_OUT` after eight bits.
- `ST_ACK_OUT` goes to the follow-up state chosen when the byte completed:
  - a read header leads to `ST_READ`;
  - a write header leads to `ST_ADDR_HI` in wide mode and to `ST_ADDR_LO` otherwise;
  - the high address byte leads to `ST_ADDR_LO`;
  - the low address byte and each data byte lead to `ST_WRITE`.
- `ST_READ` goes to `ST_ACK_IN` after eight bits.
- `ST_ACK_IN` goes back to `ST_READ` on an acknowledge and to `ST_IDLE` on a not-acknowledge.

Top module: `eeprom_target`

## Requirements
- R1: After reset, `sda_pull_o` and `busy_o` are both low.
- R2: A header byte is accepted only when bits 7:4 are 1010 and bits 3:1 equal `dev_sel_i`. Bit 0 selects the direction (1 = read, 0 = write). On any other header the target leaves SDA released on the ninth clock and ignores the bus until the next START. `sda_pull_o` stays low while a header is being shifted in.
- R3: Every accepted header, address byte and data byte is acknowledged by SDA low on the ninth clock. A byte written at an address and then fetched by a random read comes back unchanged.
- R4: With `wide_addr_i` high, two address bytes follow the header, high byte first, and the location is the low AW bits of the 16-bit value; the other bits are ignored. With `wide_addr_i` low, a single address byte selects the location.
- R5: During a write, only the low 5 pointer bits advance. A data byte following in-page offset 31 lands at offset 0 of the same 32-byte page and overwrites it.
- R6: A read header sent with no word address returns the byte at the pointer. The pointer is one past the last byte read or written, and after a write it wraps inside the page.
- R7: A read continues with the next address for as long as the controller acknowledges. The pointer advances across pages and wraps from the top of the array to 0. A not-acknowledge followed by STOP ends the read.
- R8: While `wp_i` is high, data bytes are acknowledged but not stored, and no busy window follows the STOP.
- R9: A STOP that ends a write with at least one stored byte raises `busy_o` for exactly BUSY_CYCLES clocks. While busy, the target does not acknowledge its own header. A STOP after a write with no data bytes raises no busy window.
- R10: `sda_pull_o` changes only while the synchronized SCL is low.
- R11: Written bytes reach the array only at STOP. A read inside the same transaction, after a repeated START, still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_sel_i | input | 3 | Strap bits matched against header bits 3:1 |
| wp_i | input | 1 | Write protect; 1 blocks storing data bytes |
| wide_addr_i | input | 1 | 1 = two address bytes, 0 = one address byte |
| busy_o | output | 1 | High during the post-STOP program window |

## Verification
Four properties are checked on every cycle:
- SDA is released while a header is shifting in.
- The enable changes only in an SCL-low interval.
- A busy window opens only right after a detected STOP.
- A data byte never moves the pointer out of its page.

Only the bench scenarios can show that the stored and returned bytes are right. Those scenarios cover:
- the in-page wrap of a page write;
- pointer continuity between current-address and sequential reads, including the wrap at the top of the array;
- write protection, and NACK during busy;
- deferral of writes to STOP.

A full 256-byte sequential read after writes to several pages compares every location with a model the bench computes.

// File: rtl/eet_pkg.sv
package eet_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WRITE,
        ST_ACK_OUT,
        ST_READ,
        ST_ACK_IN
    } eet_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eet_bus_sync.sv
module eet_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // bus conditions: SDA edge while SCL stays high
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eet_store.sv
module eet_store #(
    parameter int AW = 8,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    output logic          pending
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;

    logic [7:0]       mem  [DEPTH];
    logic [7:0]       pbuf [PAGE];
    logic [PAGE-1:0]  pvalid;
    logic [AW-PW-1:0] ppage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
            pvalid <= '0;
            ppage  <= '0;
        end else if (commit) begin
            // whole page buffer lands in one cycle at STOP
            for (int i = 0; i < PAGE; i++)
                if (pvalid[i]) mem[{ppage, PW'(i)}] <= pbuf[i];
            pvalid <= '0;
        end else if (wr_en) begin
            pbuf[wr_addr[PW-1:0]]   <= wr_data;
            pvalid[wr_addr[PW-1:0]] <= 1'b1;
            ppage                   <= wr_addr[AW-1:PW];
        end
    end

    assign rd_data = mem[rd_addr];
    assign pending = |pvalid;
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
    import eet_pkg::*;
#(
    parameter int AW          = 8,
    parameter int PW          = 5,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_i,
    input  logic       wide_addr_i,
    output logic       busy_o
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    eet_state_e    state_q, state_d, after_q;
    logic [2:0]    bit_cnt_q;
    logic [7:0]    shift_q, tx_q, addr_hi_q, rx_byte, rd_data;
    logic [AW-1:0] ptr_q;
    logic          sda_oe_q, ack_phase_q, mack_q;
    logic [BW-1:0] busy_cnt_q;
    logic          byte_done, hdr_match, buf_we, commit, pending;

    eet_bus_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    assign rx_byte   = {shift_q[6:0], sda_s};
    assign byte_done = scl_rise && (bit_cnt_q == 3'd7);
    assign hdr_match = (rx_byte[7:1] == {DEV_TYPE, dev_sel_i});
    assign buf_we    = (state_q == ST_WRITE) && byte_done && !wp_i;
    assign commit    = stop_det && pending;
    assign busy_o    = (busy_cnt_q != '0);
    assign sda_pull_o = sda_oe_q;

    eet_store #(.AW(AW), .PW(PW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (ptr_q),
        .rd_data (rd_data),
        .wr_en   (buf_we),
        .wr_addr (ptr_q),
        .wr_data (rx_byte),
        .commit  (commit),
        .pending (pending)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_IDLE;
            ST_HEADER:  if (byte_done) state_d = (hdr_match && !busy_o) ? ST_ACK_OUT : ST_IDLE;
            ST_ADDR_HI,
            ST_ADDR_LO,
            ST_WRITE:   if (byte_done) state_d = ST_ACK_OUT;
            ST_ACK_OUT: if (scl_fall && ack_phase_q) state_d = after_q;
            ST_READ:    if (scl_fall && bit_cnt_q == 3'd7) state_d = ST_ACK_IN;
            ST_ACK_IN:  if (scl_fall) state_d = mack_q ? ST_READ : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (stop_det)  state_d = ST_IDLE;
        if (start_det) state_d = ST_HEADER;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            shift_q     <= '0;
            tx_q        <= '0;
            addr_hi_q   <= '0;
            ptr_q       <= '0;
            sda_oe_q    <= 1'b0;
            ack_phase_q <= 1'b0;
            mack_q      <= 1'b0;
            after_q     <= ST_IDLE;
            busy_cnt_q  <= '0;
        end else begin
            if (commit)        busy_cnt_q <= BW'(BUSY_CYCLES);
            else if (busy_o)   busy_cnt_q <= busy_cnt_q - 1'b1;

            if (start_det || stop_det) begin
                sda_oe_q    <= 1'b0;
                bit_cnt_q   <= '0;
                ack_phase_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_HEADER, ST_ADDR_HI, ST_ADDR_LO, ST_WRITE: begin
                        if (scl_rise) begin
                            shift_q     <= rx_byte;
                            bit_cnt_q   <= bit_cnt_q + 1'b1;
                            ack_phase_q <= 1'b0;
                            if (bit_cnt_q == 3'd7) begin
                                if (state_q == ST_HEADER) begin
                                    addr_hi_q <= '0;
                                    after_q   <= rx_byte[0] ? ST_READ
                                               : (wide_addr_i ? ST_ADDR_HI : ST_ADDR_LO);
                                end else if (state_q == ST_ADDR_HI) begin
                                    addr_hi_q <= rx_byte;
                                    after_q   <= ST_ADDR_LO;
                                end else if (state_q == ST_ADDR_LO) begin
                                    ptr_q   <= AW'({addr_hi_q, rx_byte});
                                    after_q <= ST_WRITE;
                                end else begin
                                    // in-page advance only
                                    ptr_q   <= {ptr_q[AW-1:PW], PW'(ptr_q[PW-1:0] + 1'b1)};
                                    after_q <= ST_WRITE;
                                end
                            end
                        end
                    end
                    ST_ACK_OUT: begin
                        if (scl_fall) begin
                            if (!ack_phase_q) begin
                                sda_oe_q    <= 1'b1;
                                ack_phase_q <= 1'b1;
                            end else begin
                                ack_phase_q <= 1'b0;
                                bit_cnt_q   <= '0;
                                if (after_q == ST_READ) begin
                                    tx_q     <= rd_data;
                                    sda_oe_q <= ~rd_data[7];
                                    ptr_q    <= ptr_q + 1'b1;
                                end else begin
                                    sda_oe_q <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == 3'd7) begin
                                sda_oe_q <= 1'b0;
                            end else begin
                                sda_oe_q <= ~tx_q[6];
                                tx_q     <= {tx_q[6:0], 1'b0};
                            end
                        end
                    end
                    ST_ACK_IN: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall && mack_q) begin
                            tx_q      <= rd_data;
                            sda_oe_q  <= ~rd_data[7];
                            ptr_q     <= ptr_q + 1'b1;
                            bit_cnt_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eet_checker.sv
module eet_checker
    import eet_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input eet_state_e    state,
    input logic [AW-1:0] ptr,
    input logic          busy,
    input logic          stop_det
);
    assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    assert_header_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEADER) |-> !sda_oe);

    assert_busy_from_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_OUT && $past(state) == ST_WRITE)
            |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));
endmodule

bind eeprom_target eet_checker #(.AW(AW), .PW(PW)) u_eet_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe_q),
    .state   (state_q),
    .ptr     (ptr_q),
    .busy    (busy_o),
    .stop_det(stop_det)
);

// File: tb/test_eeprom_target.sv
`timescale 1ns/1ps
module test_eeprom_target;
    localparam int BUSY = 600;
    localparam int QTR  = 8;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0, rst_n = 1'b0;
    logic c_scl = 1'b1, c_sda = 1'b1;
    logic wp = 1'b0, wide = 1'b0;
    logic sda_pull, busy;
    wire  sda_line = c_sda & ~sda_pull;

    int n_cmp = 0, n_bad = 0;
    int exp_mem [256];
    int mptr = 0;

    always #2 clk = ~clk;

    eeprom_target #(.AW(8), .PW(5), .BUSY_CYCLES(BUSY)) i_eeprom_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (c_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .dev_sel_i  (SEL),
        .wp_i       (wp),
        .wide_addr_i(wide),
        .busy_o     (busy)
    );

    task automatic chk(string tag, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic start_c();
        c_sda = 1; q(); c_scl = 1; q(); c_sda = 0; q(); c_scl = 0; q();
    endtask

    task automatic stop_nowait();
        c_sda = 0; q(); c_scl = 1; q(); c_sda = 1; q();
    endtask

    // STOP, then count the busy window
    task automatic stop_measure(output int n);
        c_sda = 0; q(); c_scl = 1; q(); c_sda = 1;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (busy) n++;
            else if (n > 0) break;
        end
        q();
    endtask

    task automatic put_bit(logic b);
        c_sda = b; q(); c_scl = 1; q(); q(); c_scl = 0; q();
    endtask

    task automatic get_bit(output logic b);
        c_sda = 1; q(); c_scl = 1; q(); b = sda_line; q(); c_scl = 0; q();
    endtask

    task automatic send(logic [7:0] d, output logic ack);
        for (int k = 7; k >= 0; k--) put_bit(d[k]);
        get_bit(ack);
    endtask

    task automatic recv(output logic [7:0] d, input logic last);
        logic b;
        for (int k = 7; k >= 0; k--) begin get_bit(b); d[k] = b; end
        put_bit(last);
    endtask

    task automatic send_addr(int a, string tag);
        logic ack;
        if (wide) begin send(8'hA0, ack); chk(tag, ack, 0); end
        send(8'(a), ack); chk(tag, ack, 0);
    endtask

    task automatic wr_block(int a, int n, int seed);
        logic ack; int bw; int loc;
        start_c();
        send({4'b1010, SEL, 1'b0}, ack); chk("R3 header ack", ack, 0);
        send_addr(a, "R3 addr ack");
        for (int k = 0; k < n; k++) begin
            send(8'((seed + k * 13) & 255), ack); chk("R3 data ack", ack, 0);
        end
        stop_measure(bw);
        chk(wp ? "R8 no busy" : "R9 busy length", bw, (wp || n == 0) ? 0 : BUSY);
        for (int k = 0; k < n; k++) begin
            loc = (a & 8'hE0) | ((a + k) & 8'h1F);
            if (!wp) exp_mem[loc] = (seed + k * 13) & 255;
        end
        mptr = (a & 8'hE0) | ((a + n) & 8'h1F);
    endtask

    task automatic rd_block(int a, int n, string tag);
        logic ack; logic [7:0] d;
        start_c();
        send({4'b1010, SEL, 1'b0}, ack); chk(tag, ack, 0);
        send_addr(a, tag);
        start_c();
        send({4'b1010, SEL, 1'b1}, ack); chk(tag, ack, 0);
        for (int k = 0; k < n; k++) begin
            recv(d, k == n - 1);
            chk(tag, d, exp_mem[(a + k) & 255]);
        end
        stop_nowait(); q();
        mptr = (a + n) & 255;
    endtask

    task automatic rd_cur(int n, string tag);
        logic ack; logic [7:0] d;
        start_c();
        send({4'b1010, SEL, 1'b1}, ack); chk(tag, ack, 0);
        for (int k = 0; k < n; k++) begin
            recv(d, k == n - 1);
            chk(tag, d, exp_mem[(mptr + k) & 255]);
        end
        stop_nowait(); q();
        mptr = (mptr + n) & 255;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic ack; logic [7:0] d; int bw;
        for (int i = 0; i < 256; i++) exp_mem[i] = 0;
        repeat (5) @(negedge clk);
        chk("R1 pull after reset", sda_pull, 0);
        chk("R1 busy after reset", busy, 0);
        rst_n = 1'b1;
        q();
        chk("R1 pull idle", sda_pull, 0);

        // R2: wrong strap bits and wrong type bits are not acknowledged
        start_c(); send({4'b1010, 3'b010, 1'b0}, ack); chk("R2 strap mismatch nack", ack, 1);
        send(8'h00, ack); chk("R2 ignored until START", ack, 1);
        stop_nowait(); q();
        start_c(); send({4'b1011, SEL, 1'b0}, ack); chk("R2 type mismatch nack", ack, 1);
        stop_nowait(); q();

        // R3 byte write then random read
        wr_block(8'h47, 1, 8'h5C);
        rd_block(8'h47, 1, "R3 random read");
        // R6 current address read follows the pointer
        rd_cur(2, "R6 current read");

        // R9 header refused while busy
        start_c(); send({4'b1010, SEL, 1'b0}, ack); send(8'h10, ack); send(8'h3A, ack);
        stop_nowait();
        start_c(); send({4'b1010, SEL, 1'b1}, ack); chk("R9 nack while busy", ack, 1);
        stop_nowait();
        repeat (BUSY) @(negedge clk);
        exp_mem[8'h10] = 8'h3A; mptr = 8'h11;
        chk("R9 busy ended", busy, 0);
        rd_cur(1, "R9 pointer after busy write");

        // R9 dummy write with no data starts no busy window
        start_c(); send({4'b1010, SEL, 1'b0}, ack); send(8'h22, ack);
        stop_measure(bw); chk("R9 no busy without data", bw, 0);
        mptr = 8'h22;
        rd_cur(1, "R6 after dummy write");

        // R5 page write wraps inside the page
        wr_block(8'h3E, 34, 8'h11);
        rd_block(8'h20, 32, "R5 page wrap");
        rd_cur(1, "R6 after page read");

        // R4 two-byte address mode, high byte ignored
        wide = 1'b1;
        wr_block(8'h90, 5, 8'hC3);
        rd_block(8'h90, 5, "R4 wide address");
        wide = 1'b0;

        // R8 write protect
        wp = 1'b1;
        wr_block(8'h10, 4, 8'hEE);
        wp = 1'b0;
        rd_block(8'h10, 4, "R8 protected unchanged");

        // R11 commit deferred to STOP
        start_c(); send({4'b1010, SEL, 1'b0}, ack); send(8'h80, ack); send(8'h77, ack);
        start_c(); send({4'b1010, SEL, 1'b0}, ack); send(8'h80, ack);
        start_c(); send({4'b1010, SEL, 1'b1}, ack); chk("R11 read header ack", ack, 0);
        recv(d, 1'b1); chk("R11 old data before STOP", d, exp_mem[8'h80]);
        stop_measure(bw); chk("R11 commit at STOP", bw, BUSY);
        exp_mem[8'h80] = 8'h77;
        rd_block(8'h80, 1, "R11 new data after STOP");

        // R7 near-exhaustive sweep: two more pages, then read all 256
        wr_block(8'h40, 32, 8'h05);
        wr_block(8'hE0, 32, 8'h9B);
        rd_block(8'h00, 256, "R7 sequential sweep");
        rd_cur(1, "R7 pointer wrap to 0");
        chk("R7 pull released", sda_pull, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule